// File: doc/BRIEF.md
# Channel Note-Duration Counter

This block times how long one channel of a sound generator keeps playing a note. A load strobe carries a 5-bit duration index. The index selects an 8-bit start value from a fixed 32-entry table, and that value is written into a down-counter. An external frame sequencer sends a half-frame pulse twice per sequencer cycle, in either of its modes. Each pulse lowers the count by one unless the channel's halt bit is set or the count is already zero.

The block keeps a separate active flag beside the count. A load of a non-zero value sets the flag. The flag clears when the count steps down to zero, or when software turns the channel off through its enable bit. Turning the channel off clears only the flag and leaves the stored count as it was. The flag drives both the status bit that software reads and the gate that lets the mixer pass the channel's tone. While the gate is low, the channel is silent.

Load, enable, halt and the half-frame pulse are plain control pins. None of them has back-pressure: a strobe that is present on a rising clock edge is acted on in that cycle, or it is dropped under the rules below. There is no data stream at the edge of the block, so there is no valid/ready handshake.

Top module: `chan_len_unit`

## Requirements
- R1: Driving the enable bit low never changes the stored count; only a load or a half-frame decrement changes it.
- R2: A load strobe with the enable bit high writes the table value for the index into the count on the next clock edge. In the same cycle it sets the active flag if that value is non-zero, and clears the flag if the value is zero.
- R3: When a half-frame decrement takes the count from 1 to 0, the active flag clears in the same cycle.
- R4: While the enable bit is low, the active flag is cleared on every clock edge.
- R5: The status output and the gate output both equal the active flag. They are not derived from the count, so both read 0 after a disable even while the count is non-zero.
- R6: A half-frame pulse lowers the count by one only when the count is non-zero and halt is low. With halt high, or with the count at zero, the count holds.
- R7: The duration table entry for index i is 6*i: index 0 gives 0, index 5 gives 30, and index 31 gives 186.
- R8: A load strobe while the enable bit is low is ignored. Neither the count nor the flag changes because of it.
- R9: When a load and a half-frame decrement arrive in the same cycle, the load wins and the count takes the full table value.
- R10: A synchronous reset clears the count to 0 and the active flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Load strobe for a new duration |
| index_i | input | 5 | Index into the duration table |
| enable_i | input | 1 | Channel enable bit from the control register |
| halt_i | input | 1 | Freezes the count against half-frame pulses |
| half_tick_i | input | 1 | Half-frame pulse from the frame sequencer |
| count_o | output | 8 | Remaining duration |
| active_o | output | 1 | Status bit: the active flag |
| gate_o | output | 1 | Output gate to the mixer; low forces silence |

## Verification
The bench disables the channel while the count is non-zero. A design that cleared or reloaded the count on disable would show a changed count_o, and a design that computed status from the count would still report the channel active. The bench also sends a load while the channel is disabled, a load in the same cycle as a decrement, a halted pulse, pulses at count zero, and a load of index 0. Getting these wrong would show up as a spurious load, a count one short of the table value, a count that drifts under halt or wraps to 255, or a flag set by a zero load. The bench also decrements a count of 6 all the way down. A design that dropped the flag one step early or late would be caught on the exact pulse where the flag should fall.

// File: rtl/chan_len_pkg.sv
package chan_len_pkg;
  parameter int IDX_W  = 5;
  parameter int CNT_W  = 8;
  parameter int STEP   = 6;
  localparam int DEPTH = 1 << IDX_W;

  function automatic logic [CNT_W-1:0] dur_of(input logic [IDX_W-1:0] idx);
    int unsigned v;
    v = STEP * int'(idx);
    return v[CNT_W-1:0];
  endfunction
endpackage

// File: rtl/chan_len_table.sv
module chan_len_table
  import chan_len_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  output logic [CNT_W-1:0] val_o
);
  logic [CNT_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom[g] = dur_of(IDX_W'(g));
  end

  assign val_o = rom[idx_i];
endmodule

// File: rtl/chan_len_counter.sv
module chan_len_counter
  import chan_len_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] count_o,
  output logic             to_zero_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             nonzero;

  assign nonzero   = (cnt_q != '0);
  assign to_zero_o = dec_i && !load_i && (cnt_q == CNT_W'(1));
  assign count_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                    cnt_q <= '0;
    else if (load_i)            cnt_q <= load_val_i;
    else if (dec_i && nonzero)  cnt_q <= cnt_q - CNT_W'(1);
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!load_i && cnt_q == '0) |=> cnt_q == '0); // R6

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    (load_i && dec_i) |=> cnt_q == $past(load_val_i)); // R9
endmodule

// File: rtl/chan_len_flag.sv
module chan_len_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic load_zero_i,
  input  logic drop_i,
  input  logic enable_i,
  output logic active_o
);
  logic act_q;

  always_ff @(posedge clk) begin
    if (rst)                          act_q <= 1'b0;
    else if (!enable_i)               act_q <= 1'b0;
    else if (set_i)                   act_q <= 1'b1;
    else if (load_zero_i || drop_i)   act_q <= 1'b0;
  end

  assign active_o = act_q;

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !enable_i |=> !act_q); // R4
endmodule

// File: rtl/chan_len_unit.sv
module chan_len_unit
  import chan_len_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [IDX_W-1:0] index_i,
  input  logic             enable_i,
  input  logic             halt_i,
  input  logic             half_tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             active_o,
  output logic             gate_o
);
  logic [CNT_W-1:0] tbl_val;
  logic             load_fire;
  logic             dec_req;
  logic             to_zero;
  logic             act;

  assign load_fire = load_i && enable_i;
  assign dec_req   = half_tick_i && !halt_i;

  chan_len_table u_table (
    .idx_i (index_i),
    .val_o (tbl_val)
  );

  chan_len_counter u_counter (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_fire),
    .load_val_i (tbl_val),
    .dec_i      (dec_req),
    .count_o    (count_o),
    .to_zero_o  (to_zero)
  );

  chan_len_flag u_flag (
    .clk         (clk),
    .rst         (rst),
    .set_i       (load_fire && (tbl_val != '0)),
    .load_zero_i (load_fire && (tbl_val == '0)),
    .drop_i      (to_zero),
    .enable_i    (enable_i),
    .active_o    (act)
  );

  assign active_o = act;
  assign gate_o   = act;

  AST_OFF_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
    (!enable_i && !half_tick_i) |=> $stable(count_o)); // R1

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    load_fire |=> (count_o == $past(tbl_val)) && (active_o == ($past(tbl_val) != '0))); // R2

  AST_ACTIVE_NONZERO: assert property (@(posedge clk) disable iff (rst)
    active_o |-> count_o != '0); // R3

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (half_tick_i && halt_i && !load_fire) |=> $stable(count_o)); // R6
endmodule

// File: tb/chan_len_unit_bench.sv
`timescale 1ns/1ps
module chan_len_unit_bench;
  logic       clk = 1'b0;
  logic       rst, load, en, halt, tick;
  logic [4:0] idx;
  logic [7:0] count;
  logic       active, gate;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    logic [7:0] c;
    logic       a;
    string      tag;
  } exp_t;
  exp_t q[$];

  logic [7:0] m_c = 8'd0;
  logic       m_a = 1'b0;

  always #2.5 clk = ~clk;

  chan_len_unit u_chan_len_unit (
    .clk(clk), .rst(rst), .load_i(load), .index_i(idx), .enable_i(en),
    .halt_i(halt), .half_tick_i(tick), .count_o(count), .active_o(active), .gate_o(gate)
  );

  // driver: apply one cycle of stimulus, predict the result from the requirements
  task automatic step(input logic r, input logic l, input logic [4:0] i, input logic e,
                      input logic h, input logic t, input string tag);
    exp_t x;
    @(negedge clk);
    rst = r; load = l; idx = i; en = e; halt = h; tick = t;
    if (r) begin
      m_c = 8'd0; m_a = 1'b0;                       // R10
    end else if (l && e) begin
      m_c = 8'(6 * int'(i));                        // R7, R2, R9
      m_a = (m_c != 8'd0);
    end else begin
      if (t && !h && m_c != 8'd0) begin             // R6
        m_c = m_c - 8'd1;
        if (m_c == 8'd0) m_a = 1'b0;                // R3
      end
      if (!e) m_a = 1'b0;                           // R4, R8
    end
    x.c = m_c; x.a = m_a; x.tag = tag;
    q.push_back(x);
  endtask

  // monitor: compare after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t x;
        x = q.pop_front();
        total++;
        if (count !== x.c || active !== x.a || gate !== x.a) begin
          bad++;
          $display("FAIL %s: count=%0d active=%0b gate=%0b expected count=%0d active=%0b",
                   x.tag, count, active, gate, x.c, x.a);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1; load = 0; idx = 0; en = 0; halt = 0; tick = 0;
    step(1,0,0,0,0,0,"R10 reset");
    step(1,0,0,1,0,0,"R10 reset");
    step(0,1,5'd5,1,0,0,"R2 R7 load idx5=30");
    step(0,0,0,1,0,1,"R6 tick");
    step(0,0,0,1,0,1,"R6 tick");
    step(0,0,0,1,1,1,"R6 halt holds");
    step(0,0,0,1,1,1,"R6 halt holds");
    step(0,0,0,0,0,0,"R1 R4 R5 disable keeps count");
    step(0,0,0,0,0,0,"R1 R5 still off");
    step(0,1,5'd9,0,0,0,"R8 load while off ignored");
    step(0,0,0,0,0,1,"R6 tick while off");
    step(0,0,0,1,0,0,"R4 enable alone does not set");
    step(0,1,5'd3,1,0,1,"R9 load beats tick");
    step(0,1,5'd1,1,0,0,"R2 load idx1=6");
    for (int k = 0; k < 6; k++) step(0,0,0,1,0,1,"R3 count down to zero");
    step(0,0,0,1,0,1,"R6 zero stays zero");
    step(0,1,5'd31,1,0,0,"R7 load idx31=186");
    step(0,1,5'd0,1,0,0,"R2 zero load clears flag");
    step(0,0,0,1,0,1,"R6 tick at zero");
    step(0,1,5'd12,1,0,0,"R7 load idx12=72");
    step(1,0,0,1,0,0,"R10 reset mid run");
    step(0,0,0,1,0,0,"R10 after reset");
    @(posedge clk);
    #2;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule